// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer with nine-bit words. It has a write port and a read port, and each port runs on its own clock. The two clocks can be wired to one source, or they can run at unrelated frequencies. Both ports can move a word in the same cycle. Each port is gated by a pair of enables of opposite polarity. The write pair also selects one of two actions. In the first, the word on the data input is stored in the buffer. In the second, the low bits of the data input go into one of two threshold registers that tune the almost-empty and almost-full flags.

Read data leaves through an output register. An active-low output enable puts that output into high impedance. The read side reports empty and almost-empty. The write side reports full, almost-full and half-full. Each side computes its flags from its own pointer and a Gray-coded copy of the other side's pointer. That copy passes through a two-flop synchronizer. A flag that reacts to the far side's activity therefore lags that activity by a few of the local clock's cycles.

Top module: `prog_flag_fifo`

## Requirements
- R1: Words come out of `rd_q` in the order they were written, with all nine bits intact.
- R2: A rising `wr_clk` edge stores `wr_data` only when `wr_en_n`=0 and `wr_ld`=1. Holding both at those levels stores one word on every edge, with no gaps. When `wr_en_n`=1, nothing is stored and no threshold is loaded.
- R3: A rising `rd_clk` edge reads a word into the output register only when `rd_en_n`=0 and `rd_en`=1. With any other combination, the output register holds its value.
- R4: When `out_en_n`=1, `rd_q` is high impedance. When `out_en_n`=0, `rd_q` drives the output register.
- R5: With `wr_en_n`=0 and `wr_ld`=0, each `wr_clk` edge copies `wr_data[ADDR_W-1:0]` into a threshold register and stores no data word. The first load after reset goes to the almost-empty threshold. Later loads alternate between the almost-full and almost-empty thresholds.
- R6: Reset (`rst_n`=0, sampled on each clock) clears both pointers and the output register, and sets both thresholds to 7. After reset, `empty`=1, `almost_empty`=1, and `full`, `half_full` and `almost_full` are 0.
- R7: `full` is 1 when 2^ADDR_W words are held. A write attempted while full is ignored and leaves the write pointer unchanged.
- R8: `empty` is 1 when no word is held. A read attempted while empty is ignored, and the output register and the read pointer keep their values.
- R9: `almost_empty` is 1 when the read side's word count is at or below the almost-empty threshold.
- R10: `almost_full` is 1 when the write side's free space is at or below the almost-full threshold.
- R11: `half_full` is 1 when the write side's word count is greater than half the depth.
- R12: With independent clocks and writes and reads overlapping in time, every word arrives once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low synchronous reset, sampled by both clocks |
| wr_en_n | input | 1 | Active-low write-port enable |
| wr_ld | input | 1 | 1 = store data word, 0 = load threshold register |
| wr_data | input | DATA_W (9) | Write data, or threshold value in its low ADDR_W bits |
| rd_en_n | input | 1 | Active-low read enable |
| rd_en | input | 1 | Active-high read enable |
| out_en_n | input | 1 | Active-low output enable for `rd_q` |
| rd_q | output | DATA_W (9) | Registered read data, three-state |
| empty | output | 1 | No word held (read side) |
| almost_empty | output | 1 | Count at or below almost-empty threshold (read side) |
| half_full | output | 1 | Count above half depth (write side) |
| almost_full | output | 1 | Free space at or below almost-full threshold (write side) |
| full | output | 1 | All slots held (write side) |

## Verification
The bench keeps the default build: nine-bit words, ADDR_W=4 (16 slots) and two synchronizer stages. With only 16 slots, a test can reach the half-depth boundary (8 against 9 words) and the full condition within a few dozen writes. It can also place a threshold crossing on either side of a reset value of 7 or of a loaded value. Most scenarios run with both clocks tied to one 125 MHz source, so flag timing can be predicted exactly. The last scenario runs a 77 MHz read clock against the write clock, with a write burst and a read burst overlapping in time.

// File: rtl/pff_pkg.sv
// Shared definitions for the dual-clock FIFO.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package pff_pkg;
    // Which threshold register the next load strobe writes.
    typedef enum logic {
        SEL_EMPTY_THR = 1'b0,
        SEL_FULL_THR  = 1'b1
    } thr_sel_e;
endpackage

// File: rtl/pff_sync.sv
// Multi-flop synchronizer for a Gray-coded pointer crossing clock domains.
// Assumes STAGES >= 2 and that the input changes at most one bit per source cycle.
module pff_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the pointer through the flop chain of the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pff_mem.sv
// Storage array: writes on wr_clk, reads into an output register on rd_clk.
// Assumes the controllers never write a slot that is being read in the same cycle.
module pff_mem #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Store one word per accepted write.
    always_ff @(posedge wr_clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    // Load the output register on an accepted read; hold otherwise.
    always_ff @(posedge rd_clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= store[rd_addr];
    end
endmodule

// File: rtl/pff_wr_ctrl.sv
// Write-side control: write pointer, threshold load sequencing, and the
// full, almost-full and half-full flags.
// Assumes rgray_sync is the read pointer in Gray code, already synchronized.
module pff_wr_ctrl
    import pff_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter int ADDR_W    = 4,
    parameter int THR_RESET = 7
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              wr_ld,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic              wr_fire,
    output logic [ADDR_W:0]   wptr_bin,
    output logic [ADDR_W:0]   wptr_gray,
    output logic [ADDR_W-1:0] ae_thr,
    output logic [ADDR_W-1:0] af_thr,
    output logic              full,
    output logic              almost_full,
    output logic              half_full
);
    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);
    localparam logic [PTR_W-1:0] HALF_P  = PTR_W'(1 << (ADDR_W - 1));

    logic [PTR_W-1:0] rbin_sync;
    logic [PTR_W-1:0] used;
    logic [PTR_W-1:0] free_slots;
    logic [PTR_W-1:0] wptr_next;
    logic             store_req;
    logic             load_req;
    thr_sel_e         thr_sel;

    // Convert the synchronized Gray read pointer back to binary.
    always_comb begin
        for (int i = 0; i < PTR_W; i++) rbin_sync[i] = ^(rgray_sync >> i);
    end

    // Decode the write enables and derive the occupancy flags.
    always_comb begin
        store_req   = !wr_en_n && wr_ld;
        load_req    = !wr_en_n && !wr_ld;
        used        = wptr_bin - rbin_sync;
        free_slots  = DEPTH_P - used;
        full        = (used == DEPTH_P);
        almost_full = (free_slots <= {1'b0, af_thr});
        half_full   = (used > HALF_P);
        wr_fire     = store_req && !full;
        wptr_next   = wptr_bin + 1'b1;
    end

    // Advance the binary and Gray write pointers on an accepted write.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wptr_bin  <= '0;
            wptr_gray <= '0;
        end else if (wr_fire) begin
            wptr_bin  <= wptr_next;
            wptr_gray <= wptr_next ^ (wptr_next >> 1);
        end
    end

    // Load the threshold registers alternately, almost-empty first.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            ae_thr  <= ADDR_W'(THR_RESET);
            af_thr  <= ADDR_W'(THR_RESET);
            thr_sel <= SEL_EMPTY_THR;
        end else if (load_req) begin
            if (thr_sel == SEL_EMPTY_THR) begin
                ae_thr  <= wr_data[ADDR_W-1:0];
                thr_sel <= SEL_FULL_THR;
            end else begin
                af_thr  <= wr_data[ADDR_W-1:0];
                thr_sel <= SEL_EMPTY_THR;
            end
        end
    end
endmodule

// File: rtl/pff_rd_ctrl.sv
// Read-side control: read pointer and the empty and almost-empty flags.
// Assumes wgray_sync is the write pointer in Gray code, already synchronized,
// and that ae_thr is changed only while the read side is idle (quasi-static).
module pff_rd_ctrl #(
    parameter int ADDR_W = 4
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_en_n,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [ADDR_W-1:0] ae_thr,
    output logic              rd_fire,
    output logic [ADDR_W:0]   rptr_bin,
    output logic [ADDR_W:0]   rptr_gray,
    output logic              empty,
    output logic              almost_empty
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] wbin_sync;
    logic [PTR_W-1:0] avail;
    logic [PTR_W-1:0] rptr_next;

    // Convert the synchronized Gray write pointer back to binary.
    always_comb begin
        for (int i = 0; i < PTR_W; i++) wbin_sync[i] = ^(wgray_sync >> i);
    end

    // Derive the read-side flags and decide whether a read is accepted.
    always_comb begin
        avail        = wbin_sync - rptr_bin;
        empty        = (rptr_gray == wgray_sync);
        almost_empty = (avail <= {1'b0, ae_thr});
        rd_fire      = !rd_en_n && rd_en && !empty;
        rptr_next    = rptr_bin + 1'b1;
    end

    // Advance the binary and Gray read pointers on an accepted read.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rptr_bin  <= '0;
            rptr_gray <= '0;
        end else if (rd_fire) begin
            rptr_bin  <= rptr_next;
            rptr_gray <= rptr_next ^ (rptr_next >> 1);
        end
    end
endmodule

// File: rtl/prog_flag_fifo.sv
// Dual-clock FIFO with programmable almost-empty and almost-full thresholds.
// Each direction of the pointer crossing uses Gray code and SYNC_STAGES flops.
// Assumes rst_n is held low for several cycles of both clocks, and that
// thresholds are loaded while the read side is idle.
module prog_flag_fifo #(
    parameter int DATA_W      = 9,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int THR_RESET   = 7
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              wr_ld,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_n,
    input  logic              rd_en,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] rd_q,
    output logic              empty,
    output logic              almost_empty,
    output logic              half_full,
    output logic              almost_full,
    output logic              full
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  wr_gray;
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  rd_gray;
    logic [PTR_W-1:0]  wr_gray_at_rd;
    logic [PTR_W-1:0]  rd_gray_at_wr;
    logic [ADDR_W-1:0] ae_thr;
    logic [ADDR_W-1:0] af_thr;
    logic              wr_fire;
    logic              rd_fire;
    logic [DATA_W-1:0] q_reg;

    pff_wr_ctrl #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .THR_RESET (THR_RESET)
    ) u_wr_ctrl (
        .wr_clk      (wr_clk),
        .rst_n       (rst_n),
        .wr_en_n     (wr_en_n),
        .wr_ld       (wr_ld),
        .wr_data     (wr_data),
        .rgray_sync  (rd_gray_at_wr),
        .wr_fire     (wr_fire),
        .wptr_bin    (wr_ptr),
        .wptr_gray   (wr_gray),
        .ae_thr      (ae_thr),
        .af_thr      (af_thr),
        .full        (full),
        .almost_full (almost_full),
        .half_full   (half_full)
    );

    pff_rd_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_rd_ctrl (
        .rd_clk       (rd_clk),
        .rst_n        (rst_n),
        .rd_en_n      (rd_en_n),
        .rd_en        (rd_en),
        .wgray_sync   (wr_gray_at_rd),
        .ae_thr       (ae_thr),
        .rd_fire      (rd_fire),
        .rptr_bin     (rd_ptr),
        .rptr_gray    (rd_gray),
        .empty        (empty),
        .almost_empty (almost_empty)
    );

    pff_sync #(
        .WIDTH  (PTR_W),
        .STAGES (SYNC_STAGES)
    ) u_sync_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wr_gray),
        .q     (wr_gray_at_rd)
    );

    pff_sync #(
        .WIDTH  (PTR_W),
        .STAGES (SYNC_STAGES)
    ) u_sync_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rd_gray),
        .q     (rd_gray_at_wr)
    );

    pff_mem #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .wr_clk  (wr_clk),
        .wr_en   (wr_fire),
        .wr_addr (wr_ptr[ADDR_W-1:0]),
        .wr_data (wr_data),
        .rd_clk  (rd_clk),
        .rst_n   (rst_n),
        .rd_en   (rd_fire),
        .rd_addr (rd_ptr[ADDR_W-1:0]),
        .rd_data (q_reg)
    );

    // Three-state output driver controlled by the active-low output enable.
    assign rd_q = out_en_n ? {DATA_W{1'bz}} : q_reg;
endmodule

// File: rtl/pff_checker.sv
// Protocol and flag-consistency assertions for prog_flag_fifo, bound into it.
// Assumes the same synchronous active-low reset as the design.
module pff_checker #(
    parameter int PTR_W = 5
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst_n,
    input logic             wr_en_n,
    input logic             wr_ld,
    input logic             rd_en_n,
    input logic             rd_en,
    input logic             empty,
    input logic             almost_empty,
    input logic             half_full,
    input logic             almost_full,
    input logic             full,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr
);
    // R2
    wr_advance_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!wr_en_n && wr_ld && !full) |=> (wr_ptr == $past(wr_ptr) + 1'b1));

    // R3
    rd_advance_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!rd_en_n && rd_en && !empty) |=> (rd_ptr == $past(rd_ptr) + 1'b1));

    // R7
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full && !wr_en_n) |=> $stable(wr_ptr));

    // R8
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |=> $stable(rd_ptr) || !$past(empty));

    // R10
    full_implies_af_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |-> (almost_full && half_full));

    // R9
    empty_implies_ae_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |-> almost_empty);

    // R6
    reset_flags_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!full && !half_full && !almost_full));
endmodule

bind prog_flag_fifo pff_checker #(.PTR_W(ADDR_W + 1)) u_pff_checker (
    .wr_clk       (wr_clk),
    .rd_clk       (rd_clk),
    .rst_n        (rst_n),
    .wr_en_n      (wr_en_n),
    .wr_ld        (wr_ld),
    .rd_en_n      (rd_en_n),
    .rd_en        (rd_en),
    .empty        (empty),
    .almost_empty (almost_empty),
    .half_full    (half_full),
    .almost_full  (almost_full),
    .full         (full),
    .wr_ptr       (wr_ptr),
    .rd_ptr       (rd_ptr)
);

// File: tb/prog_flag_fifo_bench.sv
`timescale 1ns/1ps
module prog_flag_fifo_bench;
    logic       wclk = 1'b0;
    logic       rclk_free = 1'b0;
    logic       tie_clks = 1'b1;
    logic       rd_clk;
    logic       rst_n = 1'b0;
    logic       wr_en_n = 1'b1;
    logic       wr_ld = 1'b1;
    logic [8:0] wr_data = '0;
    logic       rd_en_n = 1'b1;
    logic       rd_en = 1'b0;
    logic       out_en_n = 1'b0;
    logic [8:0] rd_q;
    logic       empty, almost_empty, half_full, almost_full, full;

    int         n_checks = 0;
    int         n_fails  = 0;
    logic [8:0] model_q[$];

    always #4 wclk = ~wclk;
    always #6.5 rclk_free = ~rclk_free;
    assign rd_clk = tie_clks ? wclk : rclk_free;

    prog_flag_fifo u_prog_flag_fifo (
        .wr_clk(wclk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en_n(wr_en_n), .wr_ld(wr_ld), .wr_data(wr_data),
        .rd_en_n(rd_en_n), .rd_en(rd_en), .out_en_n(out_en_n),
        .rd_q(rd_q), .empty(empty), .almost_empty(almost_empty),
        .half_full(half_full), .almost_full(almost_full), .full(full)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (6) @(negedge wclk);
    endtask

    task automatic do_reset(input logic tied);
        rst_n = 1'b0;
        wr_en_n = 1'b1; wr_ld = 1'b1; rd_en_n = 1'b1; rd_en = 1'b0;
        tie_clks = tied;
        repeat (10) @(negedge wclk);
        rst_n = 1'b1;
        model_q.delete();
        settle();
    endtask

    task automatic push(input int n, input int base);
        @(negedge wclk);
        for (int i = 0; i < n; i++) begin
            wr_en_n = 1'b0; wr_ld = 1'b1; wr_data = 9'(base + i);
            model_q.push_back(9'(base + i));
            @(negedge wclk);
        end
        wr_en_n = 1'b1;
    endtask

    task automatic load_thr(input logic [8:0] v);
        @(negedge wclk);
        wr_en_n = 1'b0; wr_ld = 1'b0; wr_data = v;
        @(negedge wclk);
        wr_en_n = 1'b1; wr_ld = 1'b1;
    endtask

    task automatic pop(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            while (empty) @(negedge rd_clk);
            rd_en_n = 1'b0; rd_en = 1'b1;
            @(negedge rd_clk);
            rd_en_n = 1'b1; rd_en = 1'b0;
            chk(req, rd_q, model_q.pop_front());
        end
    endtask

    // R6: flags and output after reset
    task automatic t_reset_state();
        do_reset(1'b1);
        chk("R6 empty", 9'(empty), 9'd1);
        chk("R6 almost_empty", 9'(almost_empty), 9'd1);
        chk("R6 full", 9'(full), 9'd0);
        chk("R6 half_full", 9'(half_full), 9'd0);
        chk("R6 almost_full", 9'(almost_full), 9'd0);
        chk("R6 rd_q", rd_q, 9'd0);
    endtask

    // R2 R3 R1: enable gating and ordered readback
    task automatic t_gating();
        do_reset(1'b1);
        @(negedge wclk);
        wr_en_n = 1'b1; wr_ld = 1'b1; wr_data = 9'h155;
        repeat (3) @(negedge wclk);
        wr_ld = 1'b0;
        repeat (3) @(negedge wclk);
        wr_ld = 1'b1;
        settle();
        chk("R2 disabled write stores nothing", 9'(empty), 9'd1);
        chk("R2 disabled port loads no threshold", 9'(almost_empty), 9'd1);
        push(3, 9'h1A0);
        settle();
        rd_en_n = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge rd_clk);
        rd_en_n = 1'b1; rd_en = 1'b1;
        repeat (2) @(negedge rd_clk);
        rd_en_n = 1'b1; rd_en = 1'b0;
        chk("R3 gated read holds output", rd_q, 9'd0);
        pop(3, "R1 order");
    endtask

    // R11 R10 R7 R1 R4: fill, overflow attempt, drain, output enable
    task automatic t_fill();
        do_reset(1'b1);
        push(8, 9'h100);
        chk("R11 half_full at 8", 9'(half_full), 9'd0);
        chk("R10 almost_full at 8", 9'(almost_full), 9'd0);
        push(1, 9'h108);
        chk("R11 half_full at 9", 9'(half_full), 9'd1);
        chk("R10 almost_full at 9", 9'(almost_full), 9'd1);
        push(6, 9'h109);
        chk("R7 not full at 15", 9'(full), 9'd0);
        push(1, 9'h10F);
        chk("R7 full at 16", 9'(full), 9'd1);
        @(negedge wclk);
        wr_en_n = 1'b0; wr_ld = 1'b1; wr_data = 9'h1FF;
        @(negedge wclk);
        wr_en_n = 1'b1;
        chk("R7 still full after ignored write", 9'(full), 9'd1);
        pop(16, "R1 R7 drain order");
        chk("R7 empty after drain", 9'(empty), 9'd1);
        settle();
        chk("R7 full clears", 9'(full), 9'd0);
        out_en_n = 1'b1;
        #1;
        chk("R4 output released", 9'(rd_q !== 9'h10F), 9'd1);
        out_en_n = 1'b0;
        #1;
        chk("R4 output driven", rd_q, 9'h10F);
    endtask

    // R8: read while empty ignored
    task automatic t_underflow();
        logic [8:0] held;
        held = rd_q;
        @(negedge rd_clk);
        rd_en_n = 1'b0; rd_en = 1'b1;
        repeat (3) @(negedge rd_clk);
        rd_en_n = 1'b1; rd_en = 1'b0;
        chk("R8 output holds on empty read", rd_q, held);
        chk("R8 still empty", 9'(empty), 9'd1);
        push(1, 9'h0A5);
        pop(1, "R8 pointer unchanged");
    endtask

    // R9: almost-empty boundary at the reset threshold
    task automatic t_almost_empty();
        do_reset(1'b1);
        push(8, 9'h020);
        settle();
        chk("R9 count 8 above threshold", 9'(almost_empty), 9'd0);
        pop(1, "R9 data");
        chk("R9 count 7 at threshold", 9'(almost_empty), 9'd1);
        pop(7, "R9 data");
    endtask

    // R5 R9 R10: threshold loading and its alternation
    task automatic t_load();
        do_reset(1'b1);
        load_thr(9'd2);
        load_thr(9'd3);
        settle();
        chk("R5 load stores no data", 9'(empty), 9'd1);
        push(3, 9'h040);
        settle();
        chk("R5 R9 ae threshold 2 count 3", 9'(almost_empty), 9'd0);
        push(9, 9'h043);
        chk("R5 R10 af threshold 3 free 4", 9'(almost_full), 9'd0);
        push(1, 9'h04C);
        chk("R5 R10 af threshold 3 free 3", 9'(almost_full), 9'd1);
        load_thr(9'd13);
        settle();
        chk("R5 third load wraps to ae", 9'(almost_empty), 9'd1);
        pop(13, "R5 data intact");
    endtask

    // R12: independent clocks with overlapping traffic
    task automatic t_async();
        do_reset(1'b0);
        fork
            push(12, 9'h180);
            pop(12, "R12 async order");
        join
        settle();
        chk("R12 empty at end", 9'(empty), 9'd1);
        chk("R12 not full at end", 9'(full), 9'd0);
    endtask

    initial begin
        #800000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_gating();
        t_fill();
        t_underflow();
        t_almost_empty();
        t_load();
        t_async();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule